// File: doc/BRIEF.md
# SD/MMC Card Clock Generator

This block derives the card clock of an SD/MMC host from the kernel clock. A control word, written through a single-cycle write strobe, holds a divider field and a set of bus configuration bits. A non-zero divider N gives a card clock with N kernel cycles high and N kernel cycles low, so the card clock runs at the kernel frequency divided by 2N. A divider of zero passes the kernel clock straight through, except in double-data-rate mode, where pass-through is not allowed. There the block runs at divide-by-two and raises a configuration error flag.

Alongside the card clock the block produces a strobe in the kernel clock domain that marks the kernel cycle just before each card clock edge on which data logic acts. That is the rising edge in single-data-rate mode, and both edges in double-data-rate mode. It also presents the decoded bus-width, flow-control, bus-speed and clock-source bits to the rest of the host. A new divider never cuts a phase short: it takes over only at a falling edge of the card clock, so the output has no glitches. After reset the divider field holds its largest value, so the card clock runs slow and never stops.

Top module: `sdclk_gen`

## Requirements
- R1: With an active divider N > 0, the card clock is high for exactly N kernel cycles and then low for exactly N kernel cycles. N is taken from control word bits [9:0].
- R2: With divider field 0 and the DDR bit clear, the card clock follows the kernel clock combinationally and data_ce_o stays high.
- R3: With divider field 0 and the DDR bit set, the block behaves as divider 1 and cfg_err_o is high. In every other case cfg_err_o is low.
- R4: A newly written divider takes effect only at a falling edge of the card clock. The high phase in progress completes at the old length, and the low phase that follows uses the new length.
- R5: Control word bits decode, one kernel cycle after the write, as follows: bit 10 sets 4-bit bus width, bit 11 sets 8-bit bus width, bit 12 enables flow control, bit 13 selects DDR, bit 14 marks the high-speed bus, and bits [16:15] give the clock-source select.
- R6: When dividing, data_ce_o is high for exactly one kernel cycle per card clock period in SDR mode, which is the last low cycle. In DDR mode it is high for two cycles per period, the last low cycle and the last high cycle. The card clock changes on the next kernel edge after each strobe.
- R7: After reset the divider field is all ones, every mode bit and cfg_err_o is 0, and the card clock starts low.
- R8: While wr_en_i is low, the value on wr_data_i has no effect on the mode outputs or on the card clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 17 | Control word value |
| card_clk_o | output | 1 | Card clock |
| data_ce_o | output | 1 | Kernel-domain strobe before each active card clock edge |
| bus4_o | output | 1 | 4-bit bus width selected |
| bus8_o | output | 1 | 8-bit bus width selected |
| flow_ctl_o | output | 1 | Hardware flow control enabled |
| ddr_o | output | 1 | Double-data-rate mode |
| fast_bus_o | output | 1 | High-speed bus timing |
| clk_src_o | output | 2 | Sampling clock source select |
| cfg_err_o | output | 1 | DDR requested with a zero divider |

## Verification
A wrong phase counter or a wrong active divider shows up within one card clock period as a high or low phase of the wrong length, or as a strobe count other than one or two per period. A divider that is applied at the wrong moment shows as a shortened or stretched high phase directly after the write. Decode faults show on the mode pins one kernel cycle after a write. A pass-through that stays enabled in DDR mode makes the card clock track the kernel clock within two cycles of the write.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef struct packed {
      logic [1:0] clk_src;
      logic       fast_bus;
      logic       ddr;
      logic       flow_ctl;
      logic       bus8;
      logic       bus4;
   } sdclk_mode_t;

   localparam int unsigned MODE_W = $bits(sdclk_mode_t);

   function automatic sdclk_mode_t decode_mode(input logic [MODE_W-1:0] bits);
      sdclk_mode_t m;
      m.bus4     = bits[0];
      m.bus8     = bits[1];
      m.flow_ctl = bits[2];
      m.ddr      = bits[3];
      m.fast_bus = bits[4];
      m.clk_src  = bits[6:5];
      return m;
   endfunction

endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W     = 10,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned CTRL_W   = DIV_W + MODE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   output sdclk_mode_t       mode_o,
   output logic [DIV_W-1:0]  div_eff_o,
   output logic              cfg_err_o
);

   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

   logic [CTRL_W-1:0] ctrl_q;
   logic [DIV_W-1:0]  div_field;
   logic              div_zero;

   // reset: slowest divider, all mode bits clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= {{MODE_W{1'b0}}, {DIV_W{1'b1}}};
      end else if (wr_en_i) begin
         ctrl_q <= wr_data_i;
      end
   end

   assign div_field = ctrl_q[DIV_W-1:0];
   assign div_zero  = (div_field == '0);
   assign mode_o    = decode_mode(ctrl_q[CTRL_W-1:DIV_W]);
   assign cfg_err_o = mode_o.ddr & div_zero;

   generate
      if (BYPASS_EN) begin : g_bypass
         // zero selects pass-through, except in DDR mode
         always_comb begin
            div_eff_o = div_field;
            if (mode_o.ddr && div_zero) div_eff_o = DIV_ONE;
         end
      end else begin : g_no_bypass
         always_comb begin
            div_eff_o = div_zero ? DIV_ONE : div_field;
         end
      end
   endgenerate

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core #(
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             ddr_i,
   output logic             div_clk_o,
   output logic             bypass_o,
   output logic             ce_o,
   output logic [DIV_W-1:0] act_div_o,
   output logic [DIV_W-1:0] cnt_o
);

   logic [DIV_W-1:0] act_q;
   logic [DIV_W-1:0] cnt_q;
   logic             clk_q;
   logic             term;

   assign term = (cnt_q == act_q - DIV_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= '1;
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (act_q == '0) begin
         // pass-through: pick up a new value on the next kernel edge
         act_q <= div_i;
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         clk_q <= ~clk_q;
         // a new divider is only adopted at a falling edge
         if (clk_q) act_q <= div_i;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign div_clk_o = clk_q;
   assign bypass_o  = (act_q == '0);
   assign ce_o      = bypass_o | (term & (ddr_i | ~clk_q));
   assign act_div_o = act_q;
   assign cnt_o     = cnt_q;

endmodule

// File: rtl/sdclk_out_mux.sv
module sdclk_out_mux (
   input  logic clk_i,
   input  logic bypass_i,
   input  logic div_clk_i,
   output logic card_clk_o
);

   assign card_clk_o = bypass_i ? clk_i : div_clk_i;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W     = 10,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned CTRL_W   = DIV_W + MODE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   output logic              card_clk_o,
   output logic              data_ce_o,
   output logic              bus4_o,
   output logic              bus8_o,
   output logic              flow_ctl_o,
   output logic              ddr_o,
   output logic              fast_bus_o,
   output logic [1:0]        clk_src_o,
   output logic              cfg_err_o
);

   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
         $error("sdclk_gen: DIV_W must lie in 2..16");
      end
   endgenerate

   sdclk_mode_t      mode;
   logic [DIV_W-1:0] div_eff;
   logic             div_clk;
   logic             bypass;
   logic [DIV_W-1:0] act_div;
   logic [DIV_W-1:0] cnt;

   sdclk_cfg_reg #(.DIV_W(DIV_W), .BYPASS_EN(BYPASS_EN)) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .mode_o    (mode),
      .div_eff_o (div_eff),
      .cfg_err_o (cfg_err_o)
   );

   sdclk_div_core #(.DIV_W(DIV_W)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_i     (div_eff),
      .ddr_i     (mode.ddr),
      .div_clk_o (div_clk),
      .bypass_o  (bypass),
      .ce_o      (data_ce_o),
      .act_div_o (act_div),
      .cnt_o     (cnt)
   );

   sdclk_out_mux u_mux (
      .clk_i      (clk_i),
      .bypass_i   (bypass),
      .div_clk_i  (div_clk),
      .card_clk_o (card_clk_o)
   );

   assign bus4_o     = mode.bus4;
   assign bus8_o     = mode.bus8;
   assign flow_ctl_o = mode.flow_ctl;
   assign ddr_o      = mode.ddr;
   assign fast_bus_o = mode.fast_bus;
   assign clk_src_o  = mode.clk_src;

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
   parameter int unsigned DIV_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ddr,
   input logic             err,
   input logic             bypass,
   input logic             div_clk,
   input logic             ce,
   input logic [DIV_W-1:0] act_div,
   input logic [DIV_W-1:0] cnt
);

   // R3: the error flag only exists in DDR mode
   p_err_needs_ddr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err |-> ddr);

   // R3: once DDR has been held for a cycle, pass-through is never active
   p_no_bypass_ddr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ddr && $past(ddr)) |-> !bypass);

   // R1: the phase counter stays below the active divider
   p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bypass |-> (cnt < act_div));

   // R4: the active divider changes only at a falling card clock edge
   p_div_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(act_div) != '0) && !$fell(div_clk)) |-> $stable(act_div));

   // R6: every strobe while dividing is followed by a card clock edge
   p_ce_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce && !bypass) |=> (div_clk != $past(div_clk)));

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .ddr     (ddr_o),
   .err     (cfg_err_o),
   .bypass  (bypass),
   .div_clk (div_clk),
   .ce      (data_ce_o),
   .act_div (act_div),
   .cnt     (cnt)
);

// File: tb/sdclk_gen_test.sv
module sdclk_gen_test;

   localparam int DIV_W  = 10;
   localparam int CTRL_W = DIV_W + 7;
   localparam int NVEC   = 6;

   // control word, expected half period (0 = pass-through), strobes per period, error flag
   localparam logic [CTRL_W-1:0] V_WORD [NVEC] = '{17'h00403, 17'h02801, 17'h00000,
                                                  17'h02000, 17'h15005, 17'h02002};
   localparam int V_HALF [NVEC] = '{3, 1, 0, 1, 5, 2};
   localparam int V_CE   [NVEC] = '{1, 2, 0, 2, 1, 2};
   localparam int V_ERR  [NVEC] = '{0, 0, 0, 1, 0, 0};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [CTRL_W-1:0] wr_data = '0;
   logic              card_clk, data_ce, bus4, bus8, flow_ctl, ddr, fast_bus, cfg_err;
   logic [1:0]        clk_src;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int prev_half = 1023;
   logic [CTRL_W-1:0] cur_word = '0;

   always #2.5 clk = ~clk;

   sdclk_gen uut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .card_clk_o(card_clk), .data_ce_o(data_ce), .bus4_o(bus4), .bus8_o(bus8),
      .flow_ctl_o(flow_ctl), .ddr_o(ddr), .fast_bus_o(fast_bus),
      .clk_src_o(clk_src), .cfg_err_o(cfg_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic write_word(input logic [CTRL_W-1:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = ~w;
      cur_word = w;
   endtask

   task automatic measure(output int hi, output int lo, output int ce_n);
      hi = 0; lo = 0; ce_n = 0;
      @(negedge clk);
      while (card_clk) @(negedge clk);
      while (!card_clk) @(negedge clk);
      while (card_clk) begin hi++; ce_n += int'(data_ce); @(negedge clk); end
      while (!card_clk) begin lo++; ce_n += int'(data_ce); @(negedge clk); end
   endtask

   task automatic check_modes(input string tag);
      check(bus4 == cur_word[10], tag, bus4, cur_word[10]);
      check(bus8 == cur_word[11], tag, bus8, cur_word[11]);
      check(flow_ctl == cur_word[12], tag, flow_ctl, cur_word[12]);
      check(ddr == cur_word[13], tag, ddr, cur_word[13]);
      check(fast_bus == cur_word[14], tag, fast_bus, cur_word[14]);
      check(clk_src == cur_word[16:15], tag, clk_src, cur_word[16:15]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi, lo, cn;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state
      check(card_clk == 1'b0, "R7 card clock low", card_clk, 0);
      check(data_ce == 1'b0, "R7 strobe low", data_ce, 0);
      check(cfg_err == 1'b0, "R7 error low", cfg_err, 0);
      cur_word = '0;
      check_modes("R7 mode bits");
      measure(hi, lo, cn);
      check(hi == 1023, "R7 slowest high phase", hi, 1023);
      check(lo == 1023, "R7 slowest low phase", lo, 1023);

      // vector table: R1 R2 R3 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         write_word(V_WORD[i]);
         check_modes("R5 decode");
         check(int'(cfg_err) == V_ERR[i], "R3 error flag", cfg_err, V_ERR[i]);
         repeat (4 * prev_half + 8) @(negedge clk);
         if (V_HALF[i] == 0) begin
            for (int k = 0; k < 4; k++) begin
               @(posedge clk); #1;
               check(card_clk == 1'b1, "R2 pass-through high", card_clk, 1);
               check(data_ce == 1'b1, "R2 strobe held", data_ce, 1);
               @(negedge clk); #1;
               check(card_clk == 1'b0, "R2 pass-through low", card_clk, 0);
            end
         end else begin
            measure(hi, lo, cn);
            check(hi == V_HALF[i], "R1 high phase", hi, V_HALF[i]);
            check(lo == V_HALF[i], "R1 low phase", lo, V_HALF[i]);
            check(cn == V_CE[i], "R6 strobes per period", cn, V_CE[i]);
         end
         prev_half = V_HALF[i];
      end

      // R4: divider change during a high phase
      write_word(17'h00005);
      repeat (4 * prev_half + 8) @(negedge clk);
      prev_half = 5;
      while (card_clk) @(negedge clk);
      while (!card_clk) @(negedge clk);
      wr_en = 1'b1;
      wr_data = 17'h00002;
      cur_word = 17'h00002;
      hi = 0;
      while (card_clk) begin hi++; @(negedge clk); wr_en = 1'b0; end
      lo = 0;
      while (!card_clk) begin lo++; @(negedge clk); end
      cn = 0;
      while (card_clk) begin cn++; @(negedge clk); end
      check(hi == 5, "R4 old high phase kept", hi, 5);
      check(lo == 2, "R4 new low phase", lo, 2);
      check(cn == 2, "R4 new high phase", cn, 2);

      // R8: data without strobe is ignored
      wr_data = '1;
      repeat (10) @(negedge clk);
      check_modes("R8 modes unchanged");
      check(cfg_err == 1'b0, "R8 error unchanged", cfg_err, 0);
      measure(hi, lo, cn);
      check(hi == 2, "R8 period unchanged", hi, 2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule